// File: doc/BRIEF.md
# Pending Interrupt Winner Selector

This block keeps, for one processor, a cached record of the most urgent pending interrupt: its number, its priority and its group. On a start strobe it walks a range of interrupt numbers one per clock. At each step it reads three things: a 32-bit eligibility word for the word holding the current number, the priority, group and routing flag of that number. It then decides whether the candidate displaces the cached record. After the walk it compares one further candidate, which comes from a separate message-signalled source. It then pulses `done_o`.

A walk is either full or partial. A full walk first marks the record empty, then visits every implemented number. A partial walk visits only `[rng_start_i, rng_start_i + rng_len_i)`, clipped to the implemented count, and keeps the existing record as the bar to beat. A partial walk can end with no improvement while the old winner lies inside the visited range. That winner may have lost urgency, so the block restarts on its own as a full walk. Producing the eligibility words and signalling the processor are left to neighbouring logic.

Top module: `hppi_selector`

## Requirements
- R1: After reset the record holds priority 0xFF (empty), number 0, group 0, and both `busy_o` and `done_o` are low.
- R2: A smaller priority value is more urgent. After a full walk the record holds the eligible, routed entry with the smallest priority. Among equal priorities it holds the smallest number.
- R3: A full walk sets the record to empty before visiting any number. When nothing qualifies, the record ends at priority 0xFF.
- R4: A partial walk visits only numbers in `[start, start+len)`, clipped to `NUM_IDS`. Numbers outside that range are not considered. A visited candidate replaces the record when its priority is strictly smaller than the cached one.
- R5: A candidate with a priority equal to the cached one replaces the record when its number is smaller than or equal to the cached number. This also refreshes the cached group.
- R6: A partial walk can end with no replacement while the record is non-empty and its number lies within the visited range. In that case a full walk follows on its own before `done_o`. A record outside the range is kept unchanged.
- R7: An entry whose routing flag `cand_routed_i` is low is skipped, even if it is eligible and more urgent.
- R8: The external candidate is compared after the walk only when `ext_en_i` is 1, `grp1ns_en_i` is 1 and `ext_prio_i` is not 0xFF. Its group is then taken from `ext_grp_i`.
- R9: The cached group changes only together with a replacement. Changing the group input of the cached winner, with no replacement, leaves `best_grp_o` unchanged.
- R10: A start strobe seen while `busy_o` is high is ignored. The running walk keeps its range and its mode.
- R11: `done_o` is a one-cycle pulse. A walk with no restart takes (numbers visited + 3) cycles, counted from the cycle in which the start strobe is driven to the cycle in which `done_o` is observed high.
- R12: Eligibility is read one 32-bit word at a time. `word_idx_o` is the current number divided by 32, and bit (number mod 32) of `elig_word_i` marks the entry as eligible. The word is taken again on the first visited number and at every multiple of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| start_i | input | 1 | Start strobe, taken only when idle |
| full_i | input | 1 | 1 selects a full walk, 0 a partial walk |
| rng_start_i | input | ID_W | First number of a partial walk |
| rng_len_i | input | ID_W+1 | Count of numbers in a partial walk |
| scan_id_o | output | ID_W | Number visited in this cycle |
| scan_act_o | output | 1 | A number is being visited in this cycle |
| word_idx_o | output | ID_W-5 | Index of the eligibility word requested |
| elig_word_i | input | 32 | Eligibility word for `word_idx_o` |
| cand_prio_i | input | PRIO_W | Priority of `scan_id_o` |
| cand_grp_i | input | GRP_W | Group of `scan_id_o` |
| cand_routed_i | input | 1 | `scan_id_o` targets an implemented processor |
| ext_en_i | input | 1 | External source enable |
| grp1ns_en_i | input | 1 | Non-secure group 1 enable |
| ext_id_i | input | ID_W | External candidate number |
| ext_prio_i | input | PRIO_W | External candidate priority |
| ext_grp_i | input | GRP_W | External candidate group |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| best_id_o | output | ID_W | Cached winner number |
| best_prio_o | output | PRIO_W | Cached winner priority, 0xFF when empty |
| best_grp_o | output | GRP_W | Cached winner group |

## Verification
The bench exercises the tie rule at its edge. It re-walks only the cached winner at the same priority. A design that used a strict comparison would miss the replacement, restart a full walk and end on another entry with a longer latency. It also lowers the urgency of the cached winner and re-walks its range. A design without the fallback would keep reporting the stale winner. Winners are placed on both sides of 32-number word edges, which exposes an eligibility word that is not taken again at a boundary. Further cases cover a range clipped at the top, a start strobe during a walk, and each of the three conditions that gate the external candidate. Each one shows up as a wrong number, priority, group or latency.

// File: rtl/hppi_pkg.sv
package hppi_pkg;

  localparam int DEF_ID_W   = 10;
  localparam int DEF_PRIO_W = 8;
  localparam int DEF_GRP_W  = 2;
  localparam int DEF_WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EXT  = 2'd2,
    ST_CHK  = 2'd3
  } walk_state_e;

endpackage

// File: rtl/hppi_scan_ctrl.sv
module hppi_scan_ctrl
  import hppi_pkg::*;
#(
  parameter int ID_W    = DEF_ID_W,
  parameter int PRIO_W  = DEF_PRIO_W,
  parameter int NUM_IDS = 1 << DEF_ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              full_i,
  input  logic [ID_W-1:0]   rng_start_i,
  input  logic [ID_W:0]     rng_len_i,
  input  logic              seen_i,
  input  logic [ID_W-1:0]   best_id_i,
  input  logic [PRIO_W-1:0] best_prio_i,
  output logic [ID_W-1:0]   scan_id_o,
  output logic              scan_act_o,
  output logic              first_o,
  output logic              ext_act_o,
  output logic              pass_start_o,
  output logic              clear_best_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int CNT_W = ID_W + 2;
  localparam logic [CNT_W-1:0] NUM_C = CNT_W'(NUM_IDS);
  localparam logic [PRIO_W-1:0] EMPTY = {PRIO_W{1'b1}};

  walk_state_e      st_q, st_d;
  logic [CNT_W-1:0] cur_q, cur_d, lo_q, lo_d, hi_q, hi_d;
  logic             full_q, full_d, first_q, first_d, done_q, done_d;

  logic [CNT_W-1:0] req_lo, req_sum, req_hi, best_ext;
  logic             fallback;

  always_comb begin
    req_sum  = {2'b00, rng_start_i} + {1'b0, rng_len_i};
    req_lo   = full_i ? '0 : {2'b00, rng_start_i};
    req_hi   = full_i ? NUM_C : ((req_sum > NUM_C) ? NUM_C : req_sum);
    best_ext = {2'b00, best_id_i};
    fallback = !full_q && !seen_i && (best_prio_i != EMPTY) &&
               (best_ext >= lo_q) && (best_ext < hi_q);
  end

  always_comb begin
    st_d         = st_q;
    cur_d        = cur_q;
    lo_d         = lo_q;
    hi_d         = hi_q;
    full_d       = full_q;
    first_d      = first_q;
    done_d       = 1'b0;
    pass_start_o = 1'b0;
    clear_best_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          lo_d         = req_lo;
          hi_d         = req_hi;
          cur_d        = req_lo;
          full_d       = full_i;
          first_d      = 1'b1;
          pass_start_o = 1'b1;
          clear_best_o = full_i;
          st_d         = (req_lo < req_hi) ? ST_SCAN : ST_EXT;
        end
      end
      ST_SCAN: begin
        first_d = 1'b0;
        cur_d   = cur_q + 1'b1;
        if (cur_q == hi_q - 1'b1) st_d = ST_EXT;
      end
      ST_EXT: st_d = ST_CHK;
      ST_CHK: begin
        if (fallback) begin
          lo_d         = '0;
          hi_d         = NUM_C;
          cur_d        = '0;
          full_d       = 1'b1;
          first_d      = 1'b1;
          pass_start_o = 1'b1;
          clear_best_o = 1'b1;
          st_d         = ST_SCAN;
        end else begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      full_q  <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      full_q  <= full_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  assign scan_id_o  = cur_q[ID_W-1:0];
  assign scan_act_o = (st_q == ST_SCAN);
  assign first_o    = first_q;
  assign ext_act_o  = (st_q == ST_EXT);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_act_o && start_i) |=> ($stable(lo_q) && $stable(hi_q) && $stable(full_q)));

endmodule

// File: rtl/hppi_mask_hold.sv
module hppi_mask_hold
  import hppi_pkg::*;
#(
  parameter int ID_W   = DEF_ID_W,
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scan_act_i,
  input  logic                          first_i,
  input  logic [ID_W-1:0]               scan_id_i,
  input  logic [WORD_W-1:0]             elig_word_i,
  output logic [ID_W-$clog2(WORD_W)-1:0] word_idx_o,
  output logic                          elig_bit_o
);

  localparam int OFF_W = $clog2(WORD_W);

  logic [WORD_W-1:0] mask_q, live_word;
  logic [OFF_W-1:0]  bit_pos;
  logic              reload;

  always_comb begin
    bit_pos   = scan_id_i[OFF_W-1:0];
    reload    = first_i || (bit_pos == '0);
    live_word = reload ? elig_word_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (scan_act_i && reload) begin
      mask_q <= elig_word_i;
    end
  end

  assign word_idx_o = scan_id_i[ID_W-1:OFF_W];
  assign elig_bit_o = live_word[bit_pos];

  // R12
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_act_i && !reload) |=> $stable(mask_q));

endmodule

// File: rtl/hppi_best_cache.sv
module hppi_best_cache
  import hppi_pkg::*;
#(
  parameter int ID_W   = DEF_ID_W,
  parameter int PRIO_W = DEF_PRIO_W,
  parameter int GRP_W  = DEF_GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass_start_i,
  input  logic              clear_best_i,
  input  logic              cand_vld_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [GRP_W-1:0]  cand_grp_i,
  output logic [ID_W-1:0]   best_id_o,
  output logic [PRIO_W-1:0] best_prio_o,
  output logic [GRP_W-1:0]  best_grp_o,
  output logic              seen_o
);

  logic [ID_W-1:0]   id_q, id_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic              seen_q, seen_d;
  logic              wins, take;

  always_comb begin
    wins   = (cand_prio_i < prio_q) ||
             ((cand_prio_i == prio_q) && (cand_id_i <= id_q));
    take   = cand_vld_i && wins;
    id_d   = id_q;
    prio_d = prio_q;
    grp_d  = grp_q;
    seen_d = seen_q;
    if (pass_start_i) begin
      seen_d = 1'b0;
      if (clear_best_i) prio_d = {PRIO_W{1'b1}};
    end else if (take) begin
      id_d   = cand_id_i;
      prio_d = cand_prio_i;
      grp_d  = cand_grp_i;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      prio_q <= {PRIO_W{1'b1}};
      grp_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      id_q   <= id_d;
      prio_q <= prio_d;
      grp_q  <= grp_d;
      seen_q <= seen_d;
    end
  end

  assign best_id_o   = id_q;
  assign best_prio_o = prio_q;
  assign best_grp_o  = grp_q;
  assign seen_o      = seen_q;

  // R2
  prio_never_worse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vld_i && !pass_start_i) |=> (best_prio_o <= $past(best_prio_o)));

  // R9
  grp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cand_vld_i && !pass_start_i) |=> ($stable(best_grp_o) && $stable(best_id_o)));

  // R3
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_start_i && clear_best_i) |=> (best_prio_o == {PRIO_W{1'b1}}));

endmodule

// File: rtl/hppi_selector.sv
module hppi_selector
  import hppi_pkg::*;
#(
  parameter int ID_W    = DEF_ID_W,
  parameter int PRIO_W  = DEF_PRIO_W,
  parameter int GRP_W   = DEF_GRP_W,
  parameter int WORD_W  = DEF_WORD_W,
  parameter int NUM_IDS = 1 << DEF_ID_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           full_i,
  input  logic [ID_W-1:0]                rng_start_i,
  input  logic [ID_W:0]                  rng_len_i,
  output logic [ID_W-1:0]                scan_id_o,
  output logic                           scan_act_o,
  output logic [ID_W-$clog2(WORD_W)-1:0] word_idx_o,
  input  logic [WORD_W-1:0]              elig_word_i,
  input  logic [PRIO_W-1:0]              cand_prio_i,
  input  logic [GRP_W-1:0]               cand_grp_i,
  input  logic                           cand_routed_i,
  input  logic                           ext_en_i,
  input  logic                           grp1ns_en_i,
  input  logic [ID_W-1:0]                ext_id_i,
  input  logic [PRIO_W-1:0]              ext_prio_i,
  input  logic [GRP_W-1:0]               ext_grp_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic [ID_W-1:0]                best_id_o,
  output logic [PRIO_W-1:0]              best_prio_o,
  output logic [GRP_W-1:0]               best_grp_o
);

  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic              first, ext_act, pass_start, clear_best, seen, elig_bit;
  logic              scan_hit, ext_hit, cand_vld;
  logic [ID_W-1:0]   cand_id;
  logic [PRIO_W-1:0] cand_prio;
  logic [GRP_W-1:0]  cand_grp;

  hppi_scan_ctrl #(.ID_W(ID_W), .PRIO_W(PRIO_W), .NUM_IDS(NUM_IDS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_s2_q),
    .start_i      (start_i),
    .full_i       (full_i),
    .rng_start_i  (rng_start_i),
    .rng_len_i    (rng_len_i),
    .seen_i       (seen),
    .best_id_i    (best_id_o),
    .best_prio_i  (best_prio_o),
    .scan_id_o    (scan_id_o),
    .scan_act_o   (scan_act_o),
    .first_o      (first),
    .ext_act_o    (ext_act),
    .pass_start_o (pass_start),
    .clear_best_o (clear_best),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  hppi_mask_hold #(.ID_W(ID_W), .WORD_W(WORD_W)) u_mask (
    .clk         (clk),
    .rst_n       (rst_s2_q),
    .scan_act_i  (scan_act_o),
    .first_i     (first),
    .scan_id_i   (scan_id_o),
    .elig_word_i (elig_word_i),
    .word_idx_o  (word_idx_o),
    .elig_bit_o  (elig_bit)
  );

  always_comb begin
    scan_hit  = scan_act_o && elig_bit && cand_routed_i;
    ext_hit   = ext_act && ext_en_i && grp1ns_en_i &&
                (ext_prio_i != {PRIO_W{1'b1}});
    cand_vld  = scan_hit || ext_hit;
    cand_id   = ext_act ? ext_id_i   : scan_id_o;
    cand_prio = ext_act ? ext_prio_i : cand_prio_i;
    cand_grp  = ext_act ? ext_grp_i  : cand_grp_i;
  end

  hppi_best_cache #(.ID_W(ID_W), .PRIO_W(PRIO_W), .GRP_W(GRP_W)) u_best (
    .clk          (clk),
    .rst_n        (rst_s2_q),
    .pass_start_i (pass_start),
    .clear_best_i (clear_best),
    .cand_vld_i   (cand_vld),
    .cand_id_i    (cand_id),
    .cand_prio_i  (cand_prio),
    .cand_grp_i   (cand_grp),
    .best_id_o    (best_id_o),
    .best_prio_o  (best_prio_o),
    .best_grp_o   (best_grp_o),
    .seen_o       (seen)
  );

  // R7
  unrouted_skip_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (scan_act_o && !cand_routed_i) |=> $stable(best_prio_o));

  // R8
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (ext_act && !(ext_en_i && grp1ns_en_i)) |=> $stable(best_id_o));

endmodule

// File: tb/hppi_selector_tb.sv
module hppi_selector_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 96;
  localparam int ID_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            start_i = 1'b0, full_i = 1'b0;
  logic [ID_W-1:0] rng_start_i = '0;
  logic [ID_W:0]   rng_len_i = '0;
  logic [ID_W-1:0] scan_id_o;
  logic            scan_act_o;
  logic [4:0]      word_idx_o;
  logic [31:0]     elig_word_i;
  logic [7:0]      cand_prio_i;
  logic [1:0]      cand_grp_i;
  logic            cand_routed_i;
  logic            ext_en_i = 1'b0, grp1ns_en_i = 1'b0;
  logic [ID_W-1:0] ext_id_i = '0;
  logic [7:0]      ext_prio_i = 8'hFF;
  logic [1:0]      ext_grp_i = '0;
  logic            busy_o, done_o;
  logic [ID_W-1:0] best_id_o;
  logic [7:0]      best_prio_o;
  logic [1:0]      best_grp_o;

  logic       elig_a [N];
  logic       routed_a [N];
  logic [7:0] prio_a [N];
  logic [1:0] grp_a [N];

  always_comb begin
    elig_word_i = '0;
    for (int b = 0; b < 32; b++)
      if (int'(word_idx_o) * 32 + b < N) elig_word_i[b] = elig_a[int'(word_idx_o) * 32 + b];
    cand_prio_i   = (int'(scan_id_o) < N) ? prio_a[scan_id_o]   : 8'h00;
    cand_grp_i    = (int'(scan_id_o) < N) ? grp_a[scan_id_o]    : 2'b00;
    cand_routed_i = (int'(scan_id_o) < N) ? routed_a[scan_id_o] : 1'b0;
  end

  hppi_selector #(.ID_W(ID_W), .PRIO_W(8), .GRP_W(2), .WORD_W(32), .NUM_IDS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .full_i(full_i),
    .rng_start_i(rng_start_i), .rng_len_i(rng_len_i),
    .scan_id_o(scan_id_o), .scan_act_o(scan_act_o), .word_idx_o(word_idx_o),
    .elig_word_i(elig_word_i), .cand_prio_i(cand_prio_i), .cand_grp_i(cand_grp_i),
    .cand_routed_i(cand_routed_i), .ext_en_i(ext_en_i), .grp1ns_en_i(grp1ns_en_i),
    .ext_id_i(ext_id_i), .ext_prio_i(ext_prio_i), .ext_grp_i(ext_grp_i),
    .busy_o(busy_o), .done_o(done_o), .best_id_o(best_id_o),
    .best_prio_o(best_prio_o), .best_grp_o(best_grp_o)
  );

  int total = 0, bad = 0;
  int m_id = 0, m_prio = 255, m_grp = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_best(input string req);
    check(int'(best_prio_o) == m_prio, req, "prio", int'(best_prio_o), m_prio);
    if (m_prio != 255) begin
      check(int'(best_id_o) == m_id, req, "id", int'(best_id_o), m_id);
      check(int'(best_grp_o) == m_grp, req, "grp", int'(best_grp_o), m_grp);
    end
  endtask

  function automatic bit beats(input int p, input int id);
    return (p < m_prio) || (p == m_prio && id <= m_id);
  endfunction

  task automatic model_pass(input bit full_in, input int s, input int l);
    bit full = full_in, seen, again;
    int lo, hi;
    lo = full ? 0 : s;
    hi = full ? N : ((s + l > N) ? N : s + l);
    do begin
      if (full) m_prio = 255;
      seen = 0;
      for (int i = lo; i < hi; i++)
        if (elig_a[i] && routed_a[i] && beats(int'(prio_a[i]), i)) begin
          m_id = i; m_prio = int'(prio_a[i]); m_grp = int'(grp_a[i]); seen = 1;
        end
      if (ext_en_i && grp1ns_en_i && ext_prio_i != 8'hFF &&
          beats(int'(ext_prio_i), int'(ext_id_i))) begin
        m_id = int'(ext_id_i); m_prio = int'(ext_prio_i); m_grp = int'(ext_grp_i); seen = 1;
      end
      if (!full && !seen && m_prio != 255 && m_id >= lo && m_id < hi) begin
        full = 1; lo = 0; hi = N; again = 1;
      end else again = 0;
    end while (again);
  endtask

  // Runs a walk; optionally pulses a second start mid-walk. Returns cycles to done.
  task automatic run(input bit full, input int s, input int l, input bit poke,
                     output int cyc);
    @(negedge clk);
    start_i = 1'b1; full_i = full;
    rng_start_i = ID_W'(s); rng_len_i = (ID_W+1)'(l);
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 2000) begin
      if (poke && cyc == 4) begin
        start_i = 1'b1; full_i = 1'b0; rng_start_i = '0; rng_len_i = 11'd1;
      end else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    model_pass(full, s, l);
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      elig_a[i] = 1'b0; routed_a[i] = 1'b1; prio_a[i] = 8'h80; grp_a[i] = 2'd0;
    end
  endtask

  int cyc;

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(best_prio_o == 8'hFF, "R1", "reset prio", int'(best_prio_o), 255);
    check(best_id_o == '0 && best_grp_o == '0, "R1", "reset id/grp", int'(best_id_o), 0);
    check(!busy_o && !done_o, "R1", "reset busy/done", int'(busy_o), 0);

    // R3 nothing eligible -> empty
    run(1'b1, 0, 0, 1'b0, cyc);
    check_best("R3");
    // R11 latency of a full walk and pulse width
    check(cyc == N + 3, "R11", "full latency", cyc, N + 3);
    @(negedge clk);
    check(!done_o, "R11", "done width", int'(done_o), 0);

    // R2 ties: all eligible, same priority -> lowest number
    for (int i = 0; i < N; i++) begin elig_a[i] = 1'b1; prio_a[i] = 8'h07; end
    run(1'b1, 0, 0, 1'b0, cyc);
    check_best("R2");
    check(best_id_o == '0, "R2", "tie lowest", int'(best_id_o), 0);

    // R12 word boundary: only 63 and 64 eligible
    clear_all();
    elig_a[63] = 1'b1; prio_a[63] = 8'h09;
    elig_a[64] = 1'b1; prio_a[64] = 8'h08; grp_a[64] = 2'd3;
    run(1'b1, 0, 0, 1'b0, cyc);
    check_best("R12");
    elig_a[33] = 1'b1; prio_a[33] = 8'h08;
    run(1'b1, 0, 0, 1'b0, cyc);
    check_best("R12");

    // R7 unrouted more urgent entry is skipped
    clear_all();
    elig_a[10] = 1'b1; prio_a[10] = 8'h00; routed_a[10] = 1'b0;
    elig_a[50] = 1'b1; prio_a[50] = 8'h05;
    run(1'b1, 0, 0, 1'b0, cyc);
    check_best("R7");
    check(best_id_o == 10'd50, "R7", "routed winner", int'(best_id_o), 50);

    // R8 external candidate gating
    ext_id_i = 10'd700; ext_prio_i = 8'h01; ext_grp_i = 2'd1;
    ext_en_i = 1'b0; grp1ns_en_i = 1'b1;
    run(1'b1, 0, 0, 1'b0, cyc); check_best("R8");
    ext_en_i = 1'b1; grp1ns_en_i = 1'b0;
    run(1'b1, 0, 0, 1'b0, cyc); check_best("R8");
    grp1ns_en_i = 1'b1; ext_prio_i = 8'hFF;
    run(1'b1, 0, 0, 1'b0, cyc); check_best("R8");
    ext_prio_i = 8'h01;
    run(1'b1, 0, 0, 1'b0, cyc); check_best("R8");
    check(best_id_o == 10'd700, "R8", "ext wins", int'(best_id_o), 700);
    ext_en_i = 1'b0;

    // R6 fallback: cached winner in range loses urgency
    clear_all();
    elig_a[40] = 1'b1; prio_a[40] = 8'h05; grp_a[40] = 2'd1;
    elig_a[90] = 1'b1; prio_a[90] = 8'h10; grp_a[90] = 2'd2;
    run(1'b1, 0, 0, 1'b0, cyc); check_best("R2");
    prio_a[40] = 8'h80;
    run(1'b0, 32, 16, 1'b0, cyc);
    check_best("R6");
    check(best_id_o == 10'd90, "R6", "fallback winner", int'(best_id_o), 90);
    check(cyc > 16 + 3, "R6", "fallback latency", cyc, 16 + 3 + 1);

    // R6 / R9 cached winner outside range is kept, group unchanged
    elig_a[90] = 1'b0; grp_a[90] = 2'd3;
    run(1'b0, 0, 16, 1'b0, cyc);
    check_best("R9");
    check(best_id_o == 10'd90 && best_grp_o == 2'd2, "R9", "kept grp", int'(best_grp_o), 2);
    check(cyc == 16 + 3, "R6", "no fallback latency", cyc, 19);

    // R4 partial: in-range better replaces; out-of-range ignored
    elig_a[5] = 1'b1; prio_a[5] = 8'h08; grp_a[5] = 2'd0;
    elig_a[20] = 1'b1; prio_a[20] = 8'h01;
    run(1'b0, 0, 10, 1'b0, cyc);
    check_best("R4");
    check(best_id_o == 10'd5, "R4", "range limit", int'(best_id_o), 5);

    // R5 equal priority, equal number refreshes group, no restart
    grp_a[5] = 2'd1;
    run(1'b0, 5, 1, 1'b0, cyc);
    check_best("R5");
    check(cyc == 4, "R5", "no restart latency", cyc, 4);

    // R4 clipped range at the top
    run(1'b0, 90, 20, 1'b0, cyc);
    check(cyc == 6 + 3, "R4", "clipped latency", cyc, 9);
    check_best("R4");

    // R10 start during a walk is ignored
    run(1'b1, 0, 0, 1'b1, cyc);
    check(cyc == N + 3, "R10", "latency with poke", cyc, N + 3);
    check_best("R10");

    // Sweep: random full and partial walks against the model (R2, R4, R6, R7, R8)
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < N; i++) begin
        elig_a[i]   = ($urandom % 4) == 0;
        routed_a[i] = ($urandom % 8) != 0;
        prio_a[i]   = 8'($urandom % 8);
        grp_a[i]    = 2'($urandom % 4);
      end
      ext_en_i = ($urandom % 2) == 1; grp1ns_en_i = ($urandom % 4) != 0;
      ext_id_i = 10'($urandom % 1024); ext_prio_i = 8'($urandom % 10);
      ext_grp_i = 2'($urandom % 4);
      if (t % 2 == 0) begin
        run(1'b1, 0, 0, 1'b0, cyc);
        check_best("R2");
      end else begin
        run(1'b0, int'($urandom % N), int'($urandom % 40), 1'b0, cyc);
        check_best("R4/R6");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule